// File: doc/BRIEF.md
# Four-Phase Pipeline Stage Handshake Controller

This block is a clocked model of the control logic that wraps one datapath stage in a pipeline that carries data with a separate validity wire. It talks to an upstream producer through a request/acknowledge pair, to a downstream consumer through a second request/acknowledge pair, and to the stage's datapath through an enable (`dp_go`) and a completion input (`dp_fin`). The completion input is expected to come from a delay matched to the datapath logic, so the controller treats it as just another handshake input.

Each item passes through a fixed sequence of six phases. In the first half, the item arrives, the datapath is enabled, the controller waits for completion, forwards the request, waits for the consumer's acknowledge, and then acknowledges the producer. In the second half, every wire returns to zero in a fixed order, and the datapath is reset in between. The producer must keep its data stable until `in_ack` rises. The current phase is brought out for debug. A sticky flag reports handshake misuse by the neighbours.

The reset input is asynchronous and active low. It asserts at once and is released through a two-stage synchronizer, so the block comes out of reset two clock edges after `rst_n` rises.

Top module: `stg_ctrl`

## Requirements
- R1: While reset is active, and after it is released with all inputs low, `dp_go`, `out_req`, `in_ack`, `proto_err` and `phase` are all zero.
- R2: `dp_go` rises only on the edge after `in_req` was seen high while idle, and it is high exactly in phases 1, 2 and 3.
- R3: `out_req` rises only after `dp_fin` was seen high; it is high exactly in phases 2, 3 and 4.
- R4: `in_ack` rises only after `out_ack` was seen high; it is high exactly in phases 3, 4 and 5.
- R5: `dp_go` falls only after `in_req` was seen low while `in_ack` is high.
- R6: `out_req` falls only after `dp_fin` was seen low following the fall of `dp_go`.
- R7: `in_ack` falls only after `out_ack` was seen low, and this returns the controller to idle.
- R8: `phase` encodes 0 idle, 1 computing, 2 forwarding, 3 acknowledging, 4 datapath reset, 5 return to zero. The block advances one phase per clock edge at which that phase's awaited input level is present, and otherwise holds its phase.
- R9: `proto_err` is set on the edge after `in_req` falls while `in_ack` is low.
- R10: `proto_err` is set on the edge after `out_ack` rises while `out_req` is low, or falls while `out_req` is high.
- R11: Once set, `proto_err` stays set until reset, and a violation never stalls or alters the phase sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_req | input | 1 | Request from the upstream producer |
| in_ack | output | 1 | Acknowledge to the upstream producer |
| out_req | output | 1 | Request to the downstream consumer |
| out_ack | input | 1 | Acknowledge from the downstream consumer |
| dp_go | output | 1 | Datapath enable; high while the datapath computes and holds its result |
| dp_fin | input | 1 | Datapath completion from the matched delay |
| phase | output | 3 | Current handshake phase, encoded as in R8 |
| proto_err | output | 1 | Sticky handshake-violation flag |

## Verification
The protocol monitor and the phase sequencer can both act on the same clock edge. For example, `in_req` can drop too early in the computing phase at the same moment that `dp_fin` rises. The bench provokes this case on purpose. It expects the phase to move to forwarding and `proto_err` to rise on that one edge, with neither effect masking the other. Randomly timed, well-behaved neighbours run alongside. They are judged each cycle against a reference phase model and a reference error model, both kept in the bench.

// File: rtl/stg_pkg.sv
package stg_pkg;

  localparam int PH_W = 3;

  typedef enum logic [PH_W-1:0] {
    PH_IDLE = 3'd0,
    PH_GO   = 3'd1,
    PH_FWD  = 3'd2,
    PH_ACK  = 3'd3,
    PH_DROP = 3'd4,
    PH_RTZ  = 3'd5
  } stg_ph_e;

endpackage

// File: rtl/stg_rst_sync.sv
module stg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  localparam int SW = (STAGES < 2) ? 2 : STAGES;

  logic [SW-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[SW-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[SW-1];

endmodule

// File: rtl/stg_seq.sv
module stg_seq
  import stg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_req,
  input  logic            dp_fin,
  input  logic            out_ack,
  output logic            dp_go,
  output logic            out_req,
  output logic            in_ack,
  output logic [PH_W-1:0] phase
);

  stg_ph_e st_q, st_d;
  logic    adv;
  logic    go_set, go_clr, go_en;
  logic    oreq_d, iack_d;

  // next-state: each phase waits on exactly one input level
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PH_IDLE: if (in_req)   st_d = PH_GO;
      PH_GO:   if (dp_fin)   st_d = PH_FWD;
      PH_FWD:  if (out_ack)  st_d = PH_ACK;
      PH_ACK:  if (!in_req)  st_d = PH_DROP;
      PH_DROP: if (!dp_fin)  st_d = PH_RTZ;
      PH_RTZ:  if (!out_ack) st_d = PH_IDLE;
      default:               st_d = PH_IDLE;
    endcase
  end

  assign adv    = (st_d != st_q);
  assign go_set = (st_q == PH_IDLE) && in_req;
  assign go_clr = (st_q == PH_ACK) && !in_req;
  assign go_en  = go_set || go_clr;
  assign oreq_d = (st_d == PH_FWD) || (st_d == PH_ACK) || (st_d == PH_DROP);
  assign iack_d = (st_d == PH_ACK) || (st_d == PH_DROP) || (st_d == PH_RTZ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= PH_IDLE;
    else if (adv) st_q <= st_d;
  end

  // datapath-enable latch: set on acceptance, cleared once the input request drops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dp_go <= 1'b0;
    else if (go_en) dp_go <= go_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_req <= 1'b0;
      in_ack  <= 1'b0;
    end else if (adv) begin
      out_req <= oreq_d;
      in_ack  <= iack_d;
    end
  end

  assign phase = st_q;

  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (phase == '0 && !dp_go && !out_req && !in_ack));

  p_go_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dp_go) |-> $past(in_req));

  p_go_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dp_go == (phase == PH_GO || phase == PH_FWD || phase == PH_ACK));

  p_fwd_after_fin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_req) |-> $past(dp_fin));

  p_ack_after_oack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> $past(out_ack));

  p_go_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dp_go) |-> (!$past(in_req) && in_ack));

  p_fwd_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_req) |-> (!$past(dp_fin) && !dp_go));

  p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ack) |-> (!$past(out_ack) && phase == PH_IDLE));

  p_hold_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FWD && !out_ack) |=> $stable(phase));

  p_legal_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= PH_RTZ);

endmodule

// File: rtl/stg_chk.sv
module stg_chk (
  input  logic clk,
  input  logic rst_n,
  input  logic in_req,
  input  logic in_ack,
  input  logic out_req,
  input  logic out_ack,
  output logic err
);

  logic ireq_q, oack_q;
  logic early_drop, stray_oack, err_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ireq_q <= 1'b0;
      oack_q <= 1'b0;
    end else begin
      ireq_q <= in_req;
      oack_q <= out_ack;
    end
  end

  // input request withdrawn before it was acknowledged
  assign early_drop = ireq_q && !in_req && !in_ack;
  // output acknowledge moving against the request level
  assign stray_oack = (!oack_q && out_ack && !out_req) ||
                      (oack_q && !out_ack && out_req);
  assign err_set    = early_drop || stray_oack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err <= 1'b0;
    else if (err_set) err <= 1'b1;
  end

  p_early_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(in_req) && !in_ack) |=> err);

  p_stray_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_ack) && !out_req) |=> err);

  p_stray_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(out_ack) && out_req) |=> err);

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

// File: rtl/stg_ctrl.sv
module stg_ctrl
  import stg_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_req,
  output logic            in_ack,
  output logic            out_req,
  input  logic            out_ack,
  output logic            dp_go,
  input  logic            dp_fin,
  output logic [PH_W-1:0] phase,
  output logic            proto_err
);

  logic rst_n_s;

  stg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  stg_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .in_req  (in_req),
    .dp_fin  (dp_fin),
    .out_ack (out_ack),
    .dp_go   (dp_go),
    .out_req (out_req),
    .in_ack  (in_ack),
    .phase   (phase)
  );

  stg_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .in_req  (in_req),
    .in_ack  (in_ack),
    .out_req (out_req),
    .out_ack (out_ack),
    .err     (proto_err)
  );

  p_err_no_stall_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (proto_err && phase == PH_GO && dp_fin) |=> (phase == PH_FWD));

endmodule

// File: tb/tb_stg_ctrl.sv
module tb_stg_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_req, out_ack, dp_fin;
  logic       in_ack, out_req, dp_go, proto_err;
  logic [2:0] phase;

  always #5 clk = ~clk;

  stg_ctrl dut (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_ack(in_ack),
    .out_req(out_req), .out_ack(out_ack), .dp_go(dp_go), .dp_fin(dp_fin),
    .phase(phase), .proto_err(proto_err)
  );

  int n_chk = 0, n_fail = 0, items = 0;
  bit tb_done = 1'b0;
  logic [2:0] exp_ph;
  bit exp_err, p_ireq, p_oack;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] ph_next(logic [2:0] ph, bit ri, bit fi, bit oa);
    case (ph)
      3'd0: return ri  ? 3'd1 : 3'd0;
      3'd1: return fi  ? 3'd2 : 3'd1;
      3'd2: return oa  ? 3'd3 : 3'd2;
      3'd3: return !ri ? 3'd4 : 3'd3;
      3'd4: return !fi ? 3'd5 : 3'd4;
      3'd5: return !oa ? 3'd0 : 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  function automatic bit go_of(logic [2:0] ph);   return ph >= 3'd1 && ph <= 3'd3; endfunction
  function automatic bit oreq_of(logic [2:0] ph); return ph >= 3'd2 && ph <= 3'd4; endfunction
  function automatic bit iack_of(logic [2:0] ph); return ph >= 3'd3 && ph <= 3'd5; endfunction

  // called at a falling edge: check outputs, apply inputs, predict next edge
  task automatic step(input bit ri, input bit fi, input bit oa);
    chk(phase == exp_ph, "R8 phase", phase, exp_ph);
    chk(dp_go == go_of(exp_ph), "R2 R5 dp_go", dp_go, go_of(exp_ph));
    chk(out_req == oreq_of(exp_ph), "R3 R6 out_req", out_req, oreq_of(exp_ph));
    chk(in_ack == iack_of(exp_ph), "R4 R7 in_ack", in_ack, iack_of(exp_ph));
    chk(proto_err == exp_err, "R9 R10 R11 proto_err", proto_err, exp_err);
    in_req = ri; dp_fin = fi; out_ack = oa;
    if (p_ireq && !ri && !iack_of(exp_ph)) exp_err = 1'b1;
    if (!p_oack && oa && !oreq_of(exp_ph)) exp_err = 1'b1;
    if (p_oack && !oa && oreq_of(exp_ph))  exp_err = 1'b1;
    if (exp_ph == 3'd5 && !oa) items++;
    exp_ph = ph_next(exp_ph, ri, fi, oa);
    p_ireq = ri; p_oack = oa;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_req = 1'b0; dp_fin = 1'b0; out_ack = 1'b0;
    #1;
    chk({dp_go, out_req, in_ack, proto_err} == 4'b0 && phase == 3'd0,
        "R1 outputs in reset", {phase, dp_go, out_req, in_ack, proto_err}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({dp_go, out_req, in_ack, proto_err} == 4'b0 && phase == 3'd0,
        "R1 outputs after release", {phase, dp_go, out_req, in_ack, proto_err}, 0);
    exp_ph = 3'd0; exp_err = 1'b0; p_ireq = 1'b0; p_oack = 1'b0;
  endtask

  // well-behaved neighbours reacting after random delays
  task automatic rand_run(input int n);
    for (int i = 0; i < n; i++) begin
      bit ri, fi, oa;
      ri = in_req; fi = dp_fin; oa = out_ack;
      if (!in_req && !in_ack && ($urandom % 4) == 0) ri = 1'b1;
      else if (in_req && in_ack && ($urandom % 3) == 0) ri = 1'b0;
      if (dp_fin != dp_go && ($urandom % 3) == 0) fi = dp_go;
      if (out_ack != out_req && ($urandom % 3) == 0) oa = out_req;
      step(ri, fi, oa);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    in_req = 1'b0; dp_fin = 1'b0; out_ack = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R8 R4: consumer slow to acknowledge, phase holds in forwarding
    step(1, 0, 0);
    step(1, 1, 0);
    for (int k = 0; k < 10; k++) step(1, 1, 0);
    chk(phase == 3'd2 && !in_ack, "R4 hold while out_ack low", phase, 2);
    // R5: producer holds its request, datapath stays enabled
    step(1, 1, 1);
    for (int k = 0; k < 8; k++) step(1, 1, 1);
    chk(dp_go == 1'b1 && phase == 3'd3, "R5 dp_go held while in_req high", dp_go, 1);
    step(0, 1, 1);
    step(0, 1, 1);   // R6: dp_fin still high, out_req must stay
    chk(out_req == 1'b1 && phase == 3'd4, "R6 out_req held while dp_fin high", out_req, 1);
    step(0, 0, 1);
    step(0, 0, 1);
    chk(in_ack == 1'b1 && phase == 3'd5, "R7 in_ack held while out_ack high", in_ack, 1);
    step(0, 0, 0);
    step(0, 0, 0);
    chk(phase == 3'd0 && items == 1, "R8 item completed", items, 1);

    rand_run(3000);
    chk(items > 50, "R8 random items completed", items, 51);
    chk(proto_err == 1'b0, "R9 R10 no error from legal neighbours", proto_err, 0);

    // R9 R11: early drop of in_req in the same cycle as dp_fin rises
    do_reset();
    step(1, 0, 0);
    step(0, 1, 0);
    chk(phase == 3'd2 && proto_err == 1'b1, "R9 R11 error and advance same edge",
        {phase, proto_err}, 5);
    step(0, 1, 1);
    step(1, 1, 1);
    for (int k = 0; k < 6; k++) step(1, 1, 1);
    chk(proto_err == 1'b1, "R11 flag sticky", proto_err, 1);

    // R10: stray out_ack rise while idle
    do_reset();
    step(0, 0, 1);
    step(0, 0, 0);
    chk(proto_err == 1'b1 && phase == 3'd0, "R10 stray out_ack rise", proto_err, 1);

    // R10: out_ack falling while out_req still high
    do_reset();
    step(1, 0, 0);
    step(1, 1, 0);
    step(1, 1, 1);
    step(1, 1, 0);
    step(1, 1, 0);
    chk(proto_err == 1'b1 && phase == 3'd3, "R10 out_ack fall against out_req", proto_err, 1);

    do_reset();
    rand_run(1000);

    tb_done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!tb_done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule